// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar in seven packed-BCD registers: seconds, minutes, hours, day of month, month, two-digit year and a binary day-of-week. A tick enable drives it. A small prescaler turns a set number of ticks into one second step, so a one-pulse-per-second source works with `TICKS_PER_SEC` set to 1. Each step carries upward through the chain of fields. Month lengths and leap years set where the day of month wraps.

A host changes any single register through a parallel write port: an enable, a 3-bit register select and a data byte. All seven registers are always visible on their own output ports. Bit 7 of the hours register holds a 24-hour mode flag. The host sets it and reads it back. Counting always follows the 24-hour sequence whatever the flag says.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, seconds, minutes, hours, year and day-of-week read 00h, and day of month and month read 01h.
- R2: Seconds advance by one after every `TICKS_PER_SEC` tick cycles (default 4) and count in BCD from 00h to 59h. The step after 59h gives 00h and carries into the minutes.
- R3: Minutes count 00h to 59h and carry into the hours when they wrap. Hours count 00h to 23h and carry into both the day of month and the day-of-week when they wrap.
- R4: Hours bit 7 is the 24-hour flag. A write to hours stores it, and counting never changes it. Hours bit 6 always reads 0.
- R5: The day of month wraps to 01h after its last day and carries into the month. The last day is 30h for months 04h, 06h, 09h and 11h. For month 02h it is 28h, or 29h when the BCD year is a multiple of four (00h included). Every other month ends on 31h.
- R6: Month 12h wraps to 01h and carries into the year. Year 99h wraps to 00h.
- R7: Day-of-week is a binary value 0 to 6 held in bits [2:0] with bits [7:3] at 0. It wraps from 6 to 0.
- R8: A write with select 0 to 6 loads seconds, minutes, hours, day of month, month, year or day-of-week, in that order, on the next clock edge. Bits with no meaning are cleared on the load, which keeps masks 7Fh, 7Fh, BFh, 3Fh, 1Fh, FFh and 07h. Select 7 changes no register.
- R9: A valid write in the same cycle as a tick cancels that tick's effect on every register. It also restarts the sub-second phase, so the next second step comes `TICKS_PER_SEC` ticks after the write.
- R10: With no tick and no write, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Tick enable for the sub-second prescaler |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Register select (0 seconds to 6 day-of-week) |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | 24-hour flag in bit 7, hours BCD in bits [5:0] |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| wday_o | output | 8 | Day-of-week, binary in bits [2:0] |

## Verification
The checker watches the following on every cycle:
- the registers hold when the block is idle;
- the bits with no meaning stay cleared, and hours bit 6 is always 0;
- the 24-hour flag changes only through a write to hours;
- a written seconds or day-of-week value appears one cycle later;
- a write blocks a same-cycle tick from moving the seconds.

Some behaviour shows up only in the bench's scenarios:
- the carry chain through the fields;
- the month-length table and the leap-year rule, including year 00;
- the year and weekday wraparound;
- the prescaler restart after a write.

Each of these needs a chosen starting date and a counted run of ticks.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_DATE  = 3'd3,
        SEL_MONTH = 3'd4,
        SEL_YEAR  = 3'd5,
        SEL_WDAY  = 3'd6
    } reg_sel_e;

    // Per-field tens digit width, restart value and fixed top value
    localparam int          FIELD_TENS_W [NUM_FIELDS] = '{3, 3, 2, 2, 1, 4};
    localparam logic [7:0]  FIELD_MIN    [NUM_FIELDS] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
    localparam logic [7:0]  FIELD_TOP    [NUM_FIELDS] = '{8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99};

    localparam logic [2:0]  WDAY_LAST = 3'd6;

    // Multiple of four in BCD: even tens needs units 0/4/8, odd tens needs 2/6
    function automatic logic bcd_mult4(input logic [4:0] yr_low);
        logic [3:0] u;
        u = yr_low[3:0];
        if (yr_low[4])
            return (u == 4'd2) || (u == 4'd6);
        else
            return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    endfunction

endpackage

// File: rtl/bcdcal_prescaler.sv
module bcdcal_prescaler #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic step_o
);
    localparam int PH_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ps_state_t;

    ps_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        step_o = 1'b0;
        if (clr_i) begin
            st_d.phase = '0;
        end else if (tick_i) begin
            if (st_q.phase >= PH_LAST) begin
                st_d.phase = '0;
                step_o     = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bcdcal_field.sv
module bcdcal_field #(
    parameter int         TENS_W  = 3,
    parameter logic [7:0] MIN_VAL = 8'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_i,
    input  logic                load_i,
    input  logic [TENS_W+3:0]   load_val_i,
    input  logic [7:0]          top_i,
    output logic [TENS_W+3:0]   val_o,
    output logic                wrap_o
);
    localparam int VAL_W = TENS_W + 4;

    typedef struct packed {
        logic [TENS_W-1:0] tens;
        logic [3:0]        units;
    } bcd_t;

    bcd_t cnt_d, cnt_q;
    logic at_top;

    always_comb begin
        at_top = (8'(cnt_q) >= top_i);
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (inc_i) begin
            if (at_top) begin
                cnt_d  = MIN_VAL[VAL_W-1:0];
                wrap_o = 1'b1;
            end else if (cnt_q.units >= 4'd9) begin
                cnt_d.units = 4'd0;
                cnt_d.tens  = cnt_q.tens + 1'b1;
            end else begin
                cnt_d.units = cnt_q.units + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= MIN_VAL[VAL_W-1:0];
        else        cnt_q <= cnt_d;
    end

    assign val_o = cnt_q;

endmodule

// File: rtl/bcdcal_month_len.sv
module bcdcal_month_len (
    input  logic [7:0] month_i,
    input  logic [4:0] year_low_i,
    output logic [7:0] last_day_o
);
    import bcdcal_pkg::*;

    always_comb begin
        unique case (month_i)
            8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
            8'h02:                      last_day_o = bcd_mult4(year_low_i) ? 8'h29 : 8'h28;
            default:                    last_day_o = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] wday_o
);
    import bcdcal_pkg::*;

    localparam int IDX_SEC   = 0;
    localparam int IDX_HOUR  = 2;
    localparam int IDX_DATE  = 3;
    localparam int IDX_MONTH = 4;
    localparam int IDX_YEAR  = 5;

    typedef struct packed {
        logic       mode24;
        logic [2:0] wday;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                  wr_valid;
    logic                  sec_step;
    logic                  field_inc  [NUM_FIELDS];
    logic                  field_wrap [NUM_FIELDS];
    logic [7:0]            field_val  [NUM_FIELDS];
    logic [7:0]            date_last;

    assign wr_valid = wr_en_i && (wr_addr_i <= SEL_WDAY);

    bcdcal_prescaler #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .clr_i  (wr_valid),
        .step_o (sec_step)
    );

    bcdcal_month_len u_month_len (
        .month_i    (field_val[IDX_MONTH]),
        .year_low_i (field_val[IDX_YEAR][4:0]),
        .last_day_o (date_last)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam int FW = FIELD_TENS_W[g] + 4;
        logic [FW-1:0] val_raw;
        logic [7:0]    top_val;
        logic          load_me;

        if (g == IDX_SEC) begin : g_head
            assign field_inc[g] = sec_step && !wr_valid;
        end else begin : g_chain
            assign field_inc[g] = field_wrap[g-1];
        end

        if (g == IDX_DATE) begin : g_dyn_top
            assign top_val = date_last;
        end else begin : g_fix_top
            assign top_val = FIELD_TOP[g];
        end

        assign load_me = wr_valid && (wr_addr_i == 3'(g));

        bcdcal_field #(
            .TENS_W  (FIELD_TENS_W[g]),
            .MIN_VAL (FIELD_MIN[g])
        ) u_field (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_i      (field_inc[g]),
            .load_i     (load_me),
            .load_val_i (wr_data_i[FW-1:0]),
            .top_i      (top_val),
            .val_o      (val_raw),
            .wrap_o     (field_wrap[g])
        );

        assign field_val[g] = 8'(val_raw);
    end

    always_comb begin
        st_d = st_q;
        if (wr_valid && (wr_addr_i == SEL_HOUR)) begin
            st_d.mode24 = wr_data_i[7];
        end
        if (wr_valid && (wr_addr_i == SEL_WDAY)) begin
            st_d.wday = wr_data_i[2:0];
        end else if (field_wrap[IDX_HOUR]) begin
            st_d.wday = (st_q.wday >= WDAY_LAST) ? 3'd0 : st_q.wday + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_o   = field_val[0];
    assign min_o   = field_val[1];
    assign hour_o  = field_val[IDX_HOUR] | {st_q.mode24, 7'b0};
    assign date_o  = field_val[IDX_DATE];
    assign month_o = field_val[IDX_MONTH];
    assign year_o  = field_val[IDX_YEAR];
    assign wday_o  = {5'b0, st_q.wday};

endmodule

// File: rtl/bcdcal_checker.sv
module bcdcal_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [2:0] wr_addr_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic [7:0] wday_o
);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable({sec_o, min_o, hour_o, date_o, month_o, year_o, wday_o}));

    // R4
    mode_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == 3'd2) |=> $stable(hour_o[7]));

    // R4
    hour_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hour_o[6] == 1'b0);

    // R8
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[7] == 1'b0) && (min_o[7] == 1'b0) && (date_o[7:6] == 2'b0) && (month_o[7:5] == 3'b0));

    // R7
    wday_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wday_o[7:3] == 5'b0);

    // R8
    sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd0) |=> (sec_o == ($past(wr_data_i) & 8'h7F)));

    // R7
    wday_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd6) |=> (wday_o == ($past(wr_data_i) & 8'h07)));

    // R9
    write_blocks_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != 3'd0 && wr_addr_i != 3'd7) |=> $stable(sec_o));

endmodule

bind bcd_calendar_clock bcdcal_checker u_chk (.*);

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 4;
    localparam int NV         = 15;

    // byte order: sec, min, hour, date, month, year, wday
    localparam logic [55:0] PRE [NV] = '{
        56'h00_00_00_01_01_00_00,
        56'h59_10_00_01_01_00_00,
        56'h59_59_A3_15_03_24_06,
        56'h59_59_23_30_04_21_02,
        56'h59_59_23_28_02_23_01,
        56'h59_59_23_28_02_24_01,
        56'h59_59_23_29_02_24_04,
        56'h59_59_23_28_02_00_03,
        56'h59_59_23_31_12_99_05,
        56'h59_59_23_31_01_19_00,
        56'h59_59_09_07_08_15_03,
        56'h59_59_23_30_09_30_04,
        56'h59_59_23_30_11_32_06,
        56'h59_59_23_30_12_50_01,
        56'h29_09_12_10_06_88_02
    };
    localparam logic [55:0] EXP [NV] = '{
        56'h01_00_00_01_01_00_00,
        56'h00_11_00_01_01_00_00,
        56'h00_00_80_16_03_24_00,
        56'h00_00_00_01_05_21_03,
        56'h00_00_00_01_03_23_02,
        56'h00_00_00_29_02_24_02,
        56'h00_00_00_01_03_24_05,
        56'h00_00_00_29_02_00_04,
        56'h00_00_00_01_01_00_06,
        56'h00_00_00_01_02_19_01,
        56'h00_00_10_07_08_15_03,
        56'h00_00_00_01_10_30_05,
        56'h00_00_00_01_12_32_00,
        56'h00_00_00_31_12_50_02,
        56'h30_09_12_10_06_88_02
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec, mins, hour, date, month, year, wday;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_calendar_clock #(
        .TICKS_PER_SEC (TPS)
    ) u_bcd_calendar_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .sec_o     (sec),
        .min_o     (mins),
        .hour_o    (hour),
        .date_o    (date),
        .month_o   (month),
        .year_o    (year),
        .wday_o    (wday)
    );

    function automatic logic [55:0] snap();
        return {sec, mins, hour, date, month, year, wday};
    endfunction

    task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d, input logic with_tick);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick    = with_tick;
        @(negedge clk);
        wr_en = 1'b0;
        tick  = 1'b0;
    endtask

    task automatic load_all(input logic [55:0] v);
        for (int i = 0; i < 7; i++) begin
            reg_write(3'(i), v[55 - 8*i -: 8], 1'b0);
        end
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [55:0] keep;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", snap(), 56'h00_00_00_01_01_00_00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", snap(), 56'h00_00_00_01_01_00_00);

        // table: one second step from each preset (R2 R3 R4 R5 R6 R7)
        for (int v = 0; v < NV; v++) begin
            load_all(PRE[v]);
            check("R8", snap(), PRE[v]);
            run_ticks(TPS);
            check("R2/R3/R4/R5/R6/R7", snap(), EXP[v]);
        end

        // R2 / R9: phase restart and tick cancellation by a write
        load_all(56'h00_00_05_10_10_10_01);
        run_ticks(2);
        reg_write(3'd0, 8'h30, 1'b1);
        check("R9", {48'h0, sec}, {48'h0, 8'h30});
        run_ticks(TPS - 1);
        check("R9", {48'h0, sec}, {48'h0, 8'h30});
        run_ticks(1);
        check("R2", {48'h0, sec}, {48'h0, 8'h31});

        // R4: flag written and read back
        reg_write(3'd2, 8'hA3, 1'b0);
        check("R4", {48'h0, hour}, {48'h0, 8'hA3});

        // R10: idle hold
        keep = snap();
        repeat (10) @(negedge clk);
        check("R10", snap(), keep);

        // R8: select 7 ignored
        reg_write(3'd7, 8'h55, 1'b0);
        check("R8", snap(), keep);

        // R8 / R7: masking of spare bits
        load_all(56'hFF_FF_FF_FF_FF_FF_FF);
        check("R8", snap(), 56'h7F_7F_BF_3F_1F_FF_07);
        reg_write(3'd6, 8'hF6, 1'b0);
        check("R7", {48'h0, wday}, {48'h0, 8'h06});

        finish_run();
    end

endmodule